// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel or a digital TV link, all from one pixel clock. It also drives the pixel bus. A line is described by its period and its sync pulse width. Every vertical quantity is given as an absolute count of pixel clocks from the start of the frame, not as a count of lines. Because of this, a skew that moves the vertical edges off the line boundary costs nothing extra to support.

Inside the display area a smaller active window can be enabled, separately in each direction. Display pixels that fall outside an enabled window are filled with a border colour. When the pixel source reports an underflow, the underflow colour replaces the source data. A recovery option clears the underflow condition at the next frame. Each of the three strobes has its own polarity control. A one-clock frame-start pulse marks the first pixel of every frame. All timing words are captured into a shadow bank while the block is idle and again at each frame wrap. A change made in the middle of a frame therefore never tears the current frame.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, and with polarity zero, `hsyncOut`, `vsyncOut`, `deOut`, `frameStart` and `pixOut` are all 0.
- R2: The block samples `enable` high at a clock edge. Counting that edge, `frameStart` goes high after the second edge, for one clock. It repeats every `frameLength` clocks while the block runs.
- R3: `hTiming[31:16]` holds the line period in clocks and `hTiming[15:0]` holds the sync width. Active horizontal sync covers line positions 0 up to width-1.
- R4: Active vertical sync covers frame positions 0 up to `vSyncWidth`-1, counted in pixel clocks.
- R5: Data-enable is active only where the line position lies in [`hDisplay[15:0]`, `hDisplay[31:16]`] and the frame position lies in [`vDisplayStart`, `vDisplayEnd`], both bounds inclusive. Outside that area `pixOut` is 0.
- R6: `winHoriz` bit 31 enables a horizontal window [bits 15:0, bits 30:16]. `winVertStart` bit 31 enables a vertical window [bits 30:0, `winVertEnd`] in pixel clocks. Display pixels outside an enabled window show `borderColor`. Pixels inside it show `pixIn`.
- R7: `pixUnderflow` high on a window pixel makes that pixel show `underflowCfg[23:0]`. Every later window pixel shows the same colour until the block is disabled.
- R8: With `underflowCfg` bit 31 set, the underflow condition clears at the next frame start.
- R9: `syncPolarity` bit 0 inverts horizontal sync, bit 1 inverts vertical sync and bit 2 inverts data-enable. While the block is stopped, each output rests at its polarity bit.
- R10: Timing, window, colour and polarity inputs changed while the block runs take effect only from the first pixel of the next frame.
- R11: The block samples `enable` low at a clock edge. Counting that edge, all outputs return to their resting levels after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request for timing generation |
| hTiming | input | 32 | Line period [31:16], sync width [15:0] |
| hDisplay | input | 32 | Display end [31:16], display start [15:0] on the line |
| frameLength | input | 32 | Frame period in pixel clocks |
| vSyncWidth | input | 32 | Vertical sync width in pixel clocks |
| vDisplayStart | input | 32 | First display position in the frame, pixel clocks |
| vDisplayEnd | input | 32 | Last display position in the frame, pixel clocks |
| winHoriz | input | 32 | Window enable [31], end [30:16], start [15:0] |
| winVertStart | input | 32 | Window enable [31], start [30:0] in pixel clocks |
| winVertEnd | input | 32 | Window end in pixel clocks |
| syncPolarity | input | 3 | Inversion of hsync [0], vsync [1], data-enable [2] |
| borderColor | input | 24 | Colour shown outside the active window |
| underflowCfg | input | 32 | Recovery enable [31], underflow colour [23:0] |
| pixIn | input | 24 | Pixel data from the fetch path |
| pixUnderflow | input | 1 | Fetch path has no valid pixel this clock |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data-enable |
| pixOut | output | 24 | Pixel bus to the panel |
| frameStart | output | 1 | One-clock pulse on the first pixel of each frame |

## Verification
The bench models every pixel position of whole frames. It uses a vertical skew, so the display edges fall in the middle of a line. A design that counted vertical bounds in lines, or that treated an end bound as exclusive, would move data-enable by at least one pixel. The window scenario sets the border band on both sides of the window in each direction. A swapped start and end field would paint the wrong pixels. The underflow is placed mid-frame, and the bench follows it into the next frame. With recovery enabled, a latch that never clears keeps showing the underflow colour in frame two. Without recovery, a latch that clears too early shows source pixels again. The timing is rewritten mid-frame, so a design that loads registers directly corrupts the rest of the frame.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  localparam int REG_W  = 32;
  localparam int HALF_W = REG_W / 2;
  localparam int SYNC_N = 3;

  localparam int POL_HSYNC = 0;
  localparam int POL_VSYNC = 1;
  localparam int POL_DE    = 2;

  typedef struct packed {
    logic run;
    logic loadCfg;
    logic frameWrap;
  } ctrlStrobe_t;
endpackage

// File: rtl/lcd_sync_ctrl.sv
module lcd_sync_ctrl
  import lcd_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [HALF_W-1:0] hPeriod,
  input  logic [REG_W-1:0]  frameLen,
  output ctrlStrobe_t       strb,
  output logic [HALF_W-1:0] hCnt,
  output logic [REG_W-1:0]  fCnt
);
  logic running;
  logic frameEnd;
  logic lineEnd;

  assign frameEnd = running && (fCnt >= frameLen - REG_W'(1));
  assign lineEnd  = hCnt >= hPeriod - HALF_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      hCnt    <= '0;
      fCnt    <= '0;
    end else if (!running) begin
      running <= enable;
      hCnt    <= '0;
      fCnt    <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      hCnt    <= '0;
      fCnt    <= '0;
    end else if (frameEnd) begin
      hCnt <= '0;
      fCnt <= '0;
    end else begin
      fCnt <= fCnt + REG_W'(1);
      hCnt <= lineEnd ? '0 : hCnt + HALF_W'(1);
    end
  end

  always_comb begin
    strb.run       = running;
    strb.loadCfg   = !running || frameEnd;
    strb.frameWrap = frameEnd;
  end

  // R3: the line counter never reaches the programmed line period
  p_hcnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && hPeriod != '0) |-> (hCnt < hPeriod));

  // R2: the frame counter returns to the first pixel after the last one
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (running && frameEnd && enable) |=> (fCnt == '0 && hCnt == '0));

  // R2: inside a frame the position advances by one each clock
  p_fcnt_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (running && !frameEnd && enable) |=> (fCnt == $past(fCnt) + REG_W'(1)));

  // R11: a dropped enable stops the counters at the next edge
  p_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (running && !enable) |=> (!running && fCnt == '0));
endmodule

// File: rtl/lcd_sync_shadow.sv
module lcd_sync_shadow
  import lcd_sync_pkg::*;
#(
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadCfg,
  input  logic [REG_W-1:0]   hTiming,
  input  logic [REG_W-1:0]   hDisplay,
  input  logic [REG_W-1:0]   frameLength,
  input  logic [REG_W-1:0]   vSyncWidth,
  input  logic [REG_W-1:0]   vDisplayStart,
  input  logic [REG_W-1:0]   vDisplayEnd,
  input  logic [REG_W-1:0]   winHoriz,
  input  logic [REG_W-1:0]   winVertStart,
  input  logic [REG_W-1:0]   winVertEnd,
  input  logic [SYNC_N-1:0]  syncPolarity,
  input  logic [COLOR_W-1:0] borderColor,
  input  logic [REG_W-1:0]   underflowCfg,
  output logic [HALF_W-1:0]  hPeriod,
  output logic [HALF_W-1:0]  hPulse,
  output logic [HALF_W-1:0]  hStart,
  output logic [HALF_W-1:0]  hEnd,
  output logic [REG_W-1:0]   frameLen,
  output logic [REG_W-1:0]   vPulse,
  output logic [REG_W-1:0]   vStart,
  output logic [REG_W-1:0]   vEnd,
  output logic               winHEn,
  output logic [HALF_W-1:0]  winHStart,
  output logic [HALF_W-1:0]  winHEnd,
  output logic               winVEn,
  output logic [REG_W-1:0]   winVStart,
  output logic [REG_W-1:0]   winVEnd,
  output logic [SYNC_N-1:0]  pol,
  output logic [COLOR_W-1:0] borderCol,
  output logic [COLOR_W-1:0] underCol,
  output logic               recoverEn
);
  logic unusedCfgBits;
  assign unusedCfgBits = ^underflowCfg[REG_W-2:COLOR_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hPeriod   <= '0;
      hPulse    <= '0;
      hStart    <= '0;
      hEnd      <= '0;
      frameLen  <= '0;
      vPulse    <= '0;
      vStart    <= '0;
      vEnd      <= '0;
      winHEn    <= 1'b0;
      winHStart <= '0;
      winHEnd   <= '0;
      winVEn    <= 1'b0;
      winVStart <= '0;
      winVEnd   <= '0;
      pol       <= '0;
      borderCol <= '0;
      underCol  <= '0;
      recoverEn <= 1'b0;
    end else if (loadCfg) begin
      hPeriod   <= hTiming[REG_W-1:HALF_W];
      hPulse    <= hTiming[HALF_W-1:0];
      hEnd      <= hDisplay[REG_W-1:HALF_W];
      hStart    <= hDisplay[HALF_W-1:0];
      frameLen  <= frameLength;
      vPulse    <= vSyncWidth;
      vStart    <= vDisplayStart;
      vEnd      <= vDisplayEnd;
      winHEn    <= winHoriz[REG_W-1];
      winHEnd   <= {1'b0, winHoriz[REG_W-2:HALF_W]};
      winHStart <= winHoriz[HALF_W-1:0];
      winVEn    <= winVertStart[REG_W-1];
      winVStart <= {1'b0, winVertStart[REG_W-2:0]};
      winVEnd   <= winVertEnd;
      pol       <= syncPolarity;
      borderCol <= borderColor;
      underCol  <= underflowCfg[COLOR_W-1:0];
      recoverEn <= underflowCfg[REG_W-1];
    end
  end

  // R10: without a load strobe the captured timing holds still
  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !loadCfg |=> ($stable(hPeriod) && $stable(frameLen) && $stable(pol)));
endmodule

// File: rtl/lcd_sync_datapath.sv
module lcd_sync_datapath
  import lcd_sync_pkg::*;
#(
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [HALF_W-1:0]  hCnt,
  input  logic [REG_W-1:0]   fCnt,
  input  logic [HALF_W-1:0]  hPulse,
  input  logic [HALF_W-1:0]  hStart,
  input  logic [HALF_W-1:0]  hEnd,
  input  logic [REG_W-1:0]   frameLen,
  input  logic [REG_W-1:0]   vPulse,
  input  logic [REG_W-1:0]   vStart,
  input  logic [REG_W-1:0]   vEnd,
  input  logic               winHEn,
  input  logic [HALF_W-1:0]  winHStart,
  input  logic [HALF_W-1:0]  winHEnd,
  input  logic               winVEn,
  input  logic [REG_W-1:0]   winVStart,
  input  logic [REG_W-1:0]   winVEnd,
  input  logic [SYNC_N-1:0]  pol,
  input  logic [COLOR_W-1:0] borderCol,
  input  logic [COLOR_W-1:0] underCol,
  input  logic               recoverEn,
  input  logic [COLOR_W-1:0] pixIn,
  input  logic               pixUnderflow,
  output logic [SYNC_N-1:0]  syncOut,
  output logic [COLOR_W-1:0] pixOut,
  output logic               frameStart
);
  logic               hsActive;
  logic               vsActive;
  logic               inHDisp;
  logic               inVDisp;
  logic               inDisp;
  logic               inHWin;
  logic               inVWin;
  logic               inWin;
  logic               ufHit;
  logic               ufLatched;
  logic [SYNC_N-1:0]  activeVec;
  logic [COLOR_W-1:0] colorSel;

  always_comb begin
    hsActive = hCnt < hPulse;
    vsActive = fCnt < vPulse;
    inHDisp  = (hCnt >= hStart) && (hCnt <= hEnd);
    inVDisp  = (fCnt >= vStart) && (fCnt <= vEnd);
    inDisp   = inHDisp && inVDisp;
    inHWin   = !winHEn || ((hCnt >= winHStart) && (hCnt <= winHEnd));
    inVWin   = !winVEn || ((fCnt >= winVStart) && (fCnt <= winVEnd));
    inWin    = inHWin && inVWin;
    ufHit    = inDisp && inWin && pixUnderflow;
    activeVec[POL_HSYNC] = hsActive;
    activeVec[POL_VSYNC] = vsActive;
    activeVec[POL_DE]    = inDisp;
  end

  always_comb begin
    if (!inDisp)                   colorSel = '0;
    else if (!inWin)               colorSel = borderCol;
    else if (ufLatched || ufHit)   colorSel = underCol;
    else                           colorSel = pixIn;
  end

  for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
    logic syncQ;
    always_ff @(posedge clk) begin
      if (!rstN)          syncQ <= 1'b0;
      else if (strb.run)  syncQ <= activeVec[i] ^ pol[i];
      else                syncQ <= pol[i];
    end
    assign syncOut[i] = syncQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut     <= '0;
      frameStart <= 1'b0;
      ufLatched  <= 1'b0;
    end else begin
      pixOut     <= strb.run ? colorSel : '0;
      frameStart <= strb.run && (fCnt == '0);
      if (!strb.run)                         ufLatched <= 1'b0;
      else if (strb.frameWrap && recoverEn)  ufLatched <= 1'b0;
      else if (ufHit)                        ufLatched <= 1'b1;
    end
  end

  // R2: the frame-start pulse lasts a single clock
  p_fs_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && frameLen > REG_W'(1)) |=> !frameStart);

  // R5: outside the display area the pixel bus is black and DE rests
  p_outside_black_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !inDisp) |=> (pixOut == '0 && syncOut[POL_DE] == $past(pol[POL_DE])));

  // R6: display pixels outside the enabled window carry the border colour
  p_border_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && inDisp && !inWin) |=> (pixOut == $past(borderCol)));

  // R7: a window pixel that underflows shows the underflow colour
  p_underflow_col_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && ufHit) |=> (pixOut == $past(underCol)));

  // R7: the underflow condition persists until a recovery wrap
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && ufLatched && !(strb.frameWrap && recoverEn)) |=> ufLatched);

  // R9: a stopped block rests DE at its polarity level
  p_idle_de_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (syncOut[POL_DE] == $past(pol[POL_DE])));
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [31:0]        hTiming,
  input  logic [31:0]        hDisplay,
  input  logic [31:0]        frameLength,
  input  logic [31:0]        vSyncWidth,
  input  logic [31:0]        vDisplayStart,
  input  logic [31:0]        vDisplayEnd,
  input  logic [31:0]        winHoriz,
  input  logic [31:0]        winVertStart,
  input  logic [31:0]        winVertEnd,
  input  logic [2:0]         syncPolarity,
  input  logic [COLOR_W-1:0] borderColor,
  input  logic [31:0]        underflowCfg,
  input  logic [COLOR_W-1:0] pixIn,
  input  logic               pixUnderflow,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic [COLOR_W-1:0] pixOut,
  output logic               frameStart
);
  ctrlStrobe_t        strb;
  logic [HALF_W-1:0]  hCnt;
  logic [REG_W-1:0]   fCnt;
  logic [HALF_W-1:0]  hPeriod, hPulse, hStart, hEnd;
  logic [REG_W-1:0]   frameLen, vPulse, vStart, vEnd;
  logic               winHEn, winVEn, recoverEn;
  logic [HALF_W-1:0]  winHStart, winHEnd;
  logic [REG_W-1:0]   winVStart, winVEnd;
  logic [SYNC_N-1:0]  pol;
  logic [COLOR_W-1:0] borderCol, underCol;
  logic [SYNC_N-1:0]  syncOut;

  lcd_sync_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hPeriod(hPeriod), .frameLen(frameLen),
    .strb(strb), .hCnt(hCnt), .fCnt(fCnt)
  );

  lcd_sync_shadow #(.COLOR_W(COLOR_W)) u_shadow (
    .clk(clk), .rstN(rstN), .loadCfg(strb.loadCfg),
    .hTiming(hTiming), .hDisplay(hDisplay), .frameLength(frameLength),
    .vSyncWidth(vSyncWidth), .vDisplayStart(vDisplayStart),
    .vDisplayEnd(vDisplayEnd), .winHoriz(winHoriz),
    .winVertStart(winVertStart), .winVertEnd(winVertEnd),
    .syncPolarity(syncPolarity), .borderColor(borderColor),
    .underflowCfg(underflowCfg),
    .hPeriod(hPeriod), .hPulse(hPulse), .hStart(hStart), .hEnd(hEnd),
    .frameLen(frameLen), .vPulse(vPulse), .vStart(vStart), .vEnd(vEnd),
    .winHEn(winHEn), .winHStart(winHStart), .winHEnd(winHEnd),
    .winVEn(winVEn), .winVStart(winVStart), .winVEnd(winVEnd),
    .pol(pol), .borderCol(borderCol), .underCol(underCol),
    .recoverEn(recoverEn)
  );

  lcd_sync_datapath #(.COLOR_W(COLOR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hCnt(hCnt), .fCnt(fCnt),
    .hPulse(hPulse), .hStart(hStart), .hEnd(hEnd), .frameLen(frameLen),
    .vPulse(vPulse), .vStart(vStart), .vEnd(vEnd),
    .winHEn(winHEn), .winHStart(winHStart), .winHEnd(winHEnd),
    .winVEn(winVEn), .winVStart(winVStart), .winVEnd(winVEnd),
    .pol(pol), .borderCol(borderCol), .underCol(underCol),
    .recoverEn(recoverEn), .pixIn(pixIn), .pixUnderflow(pixUnderflow),
    .syncOut(syncOut), .pixOut(pixOut), .frameStart(frameStart)
  );

  assign hsyncOut = syncOut[POL_HSYNC];
  assign vsyncOut = syncOut[POL_VSYNC];
  assign deOut    = syncOut[POL_DE];
endmodule

// File: tb/tb_lcd_sync_gen.sv
module tb_lcd_sync_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] hTiming = '0, hDisplay = '0, frameLength = '0, vSyncWidth = '0;
  logic [31:0] vDisplayStart = '0, vDisplayEnd = '0;
  logic [31:0] winHoriz = '0, winVertStart = '0, winVertEnd = '0;
  logic [2:0]  syncPolarity = '0;
  logic [23:0] borderColor = '0;
  logic [31:0] underflowCfg = '0;
  logic [23:0] pixIn = '0;
  logic        pixUnderflow = 1'b0;
  logic        hsyncOut, vsyncOut, deOut, frameStart;
  logic [23:0] pixOut;

  int checks = 0;
  int errors = 0;

  // model state
  logic [31:0] sHt, sHd, sFl, sVp, sVs, sVe, sWh, sWvs, sWve, sUc;
  logic [2:0]  sPol;
  logic [23:0] sBc;
  int          pos = 0;
  int          cycleIdx = 0;
  int          ufCycle = -1;
  bit          mLatch = 0;
  bit          havePrev = 0;
  logic        pH, pV, pD, pF;
  logic [23:0] pP;

  lcd_sync_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hTiming(hTiming), .hDisplay(hDisplay), .frameLength(frameLength),
    .vSyncWidth(vSyncWidth), .vDisplayStart(vDisplayStart),
    .vDisplayEnd(vDisplayEnd), .winHoriz(winHoriz),
    .winVertStart(winVertStart), .winVertEnd(winVertEnd),
    .syncPolarity(syncPolarity), .borderColor(borderColor),
    .underflowCfg(underflowCfg), .pixIn(pixIn), .pixUnderflow(pixUnderflow),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pixOut(pixOut), .frameStart(frameStart)
  );

  always #5ns clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at position %0d: actual %h expected %h", tag, what, pos, act, exp);
    end
  endtask

  task automatic setCfg1();
    hTiming = {16'd20, 16'd3};  hDisplay = {16'd15, 16'd6};
    frameLength = 32'd140;  vSyncWidth = 32'd20;
    vDisplayStart = 32'd42; vDisplayEnd = 32'd121;
    winHoriz = '0; winVertStart = '0; winVertEnd = '0;
    syncPolarity = 3'b000; borderColor = 24'h0000AA;
    underflowCfg = {8'h00, 24'hFF00FF};
  endtask

  task automatic setCfg2();
    hTiming = {16'd16, 16'd2};  hDisplay = {16'd11, 16'd4};
    frameLength = 32'd112;  vSyncWidth = 32'd16;
    vDisplayStart = 32'd32; vDisplayEnd = 32'd95;
    borderColor = 24'h00CC00;
  endtask

  // one clock: compare the previous position, drive and predict the current one
  task automatic stepCycles(int n, string pixTag);
    for (int k = 0; k < n; k++) begin
      int  h;
      bit  inDisp, inWin, hit, useU;
      @(negedge clk);
      if (havePrev) begin
        chk("R3", "hsync", 32'(hsyncOut), 32'(pH));
        chk("R4", "vsync", 32'(vsyncOut), 32'(pV));
        chk("R5", "de", 32'(deOut), 32'(pD));
        chk("R2", "frameStart", 32'(frameStart), 32'(pF));
        chk(pixTag, "pixOut", 32'(pixOut), 32'(pP));
      end
      if (pos == 0) begin
        sHt = hTiming; sHd = hDisplay; sFl = frameLength; sVp = vSyncWidth;
        sVs = vDisplayStart; sVe = vDisplayEnd; sWh = winHoriz;
        sWvs = winVertStart; sWve = winVertEnd; sUc = underflowCfg;
        sPol = syncPolarity; sBc = borderColor;
      end
      pixIn = {8'h5A, cycleIdx[15:0]};
      pixUnderflow = (cycleIdx == ufCycle);
      h = pos % int'(sHt[31:16]);
      inDisp = (h >= int'(sHd[15:0])) && (h <= int'(sHd[31:16])) &&
               (pos >= int'(sVs)) && (pos <= int'(sVe));
      inWin = (!sWh[31] || ((h >= int'(sWh[15:0])) && (h <= int'(sWh[30:16])))) &&
              (!sWvs[31] || ((pos >= int'(sWvs[30:0])) && (pos <= int'(sWve))));
      hit  = inDisp && inWin && pixUnderflow;
      useU = mLatch || hit;
      pH = (h < int'(sHt[15:0])) ^ sPol[0];
      pV = (pos < int'(sVp)) ^ sPol[1];
      pD = inDisp ^ sPol[2];
      pF = (pos == 0);
      pP = !inDisp ? 24'h0 : (!inWin ? sBc : (useU ? sUc[23:0] : pixIn));
      if (pos == int'(sFl) - 1 && sUc[31]) mLatch = 0;
      else if (hit) mLatch = 1;
      pos = (pos == int'(sFl) - 1) ? 0 : pos + 1;
      cycleIdx++;
      havePrev = 1;
    end
  endtask

  task automatic startRun();
    @(negedge clk);
    enable = 1'b1;
    pos = 0; mLatch = 0; havePrev = 0;
    @(posedge clk);
  endtask

  task automatic checkIdle(string tag);
    chk(tag, "idle hsync", 32'(hsyncOut), 32'(syncPolarity[0]));
    chk(tag, "idle vsync", 32'(vsyncOut), 32'(syncPolarity[1]));
    chk(tag, "idle de", 32'(deOut), 32'(syncPolarity[2]));
    chk(tag, "idle pix", 32'(pixOut), 32'h0);
    chk(tag, "idle frameStart", 32'(frameStart), 32'h0);
  endtask

  // R11: drop enable, then outputs rest two edges later
  task automatic stopRun();
    @(negedge clk);
    chk("R3", "hsync", 32'(hsyncOut), 32'(pH));
    chk("R5", "de", 32'(deOut), 32'(pD));
    enable = 1'b0;
    pixUnderflow = 1'b0;
    ufCycle = -1;
    @(negedge clk);
    @(negedge clk);
    checkIdle("R11");
    havePrev = 0;
  endtask

  task automatic testReset();
    @(negedge clk);
    checkIdle("R1");
  endtask

  task automatic testBasic();
    setCfg1();
    startRun();
    stepCycles(280, "R5");
    stopRun();
  endtask

  task automatic testWindow();
    setCfg1();
    winHoriz = {1'b1, 15'd12, 16'd8};
    winVertStart = {1'b1, 31'd60};
    winVertEnd = 32'd100;
    startRun();
    stepCycles(140, "R6");
    stopRun();
  endtask

  task automatic testUnderflow(bit recover, string tag);
    setCfg1();
    underflowCfg = {recover, 7'h00, 24'hFF00FF};
    startRun();
    ufCycle = cycleIdx + 70;
    stepCycles(280, tag);
    stopRun();
  endtask

  task automatic testPolarity();
    setCfg1();
    syncPolarity = 3'b111;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    checkIdle("R9");
    startRun();
    stepCycles(140, "R9");
    stopRun();
    syncPolarity = 3'b000;
  endtask

  task automatic testMidFrameChange();
    setCfg1();
    startRun();
    stepCycles(60, "R10");
    setCfg2();
    stepCycles(80 + 224, "R10");
    stopRun();
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL R2 watchdog: actual still running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testWindow();
    testUnderflow(1'b0, "R7");
    testUnderflow(1'b1, "R8");
    testPolarity();
    testMidFrameChange();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule